// File: doc/BRIEF.md
# Receive Buffer Empty Indicator Pin Multiplexer

This block owns the single interrupt pin of a radio receiver. Normally the pin carries the interrupt request. While a host reads the receive frame buffer over SPI, the pin can instead report whether another byte is ready to read. The host can then start each SPI byte cycle as soon as data is there, and does not have to wait for the whole frame. The indicator mode is taken only when the enable control bit is set at the moment the read command completes.

A toggle from the SPI clock domain marks the completed read command. A second toggle marks each byte shifted out to the host. Both are synchronised into the system clock. The block counts the bytes read and compares that count with the buffer's write count. After the command, a programmable settling delay passes before the comparison is shown. A receive error during the read forces the pin to "not ready" until the host deselects. Interrupts raised during the read are held and appear on the pin as soon as select rises.

The SPI shifter, the buffer memory, the receive path and the interrupt sources are outside the block.

Top module: `frbuf_empty_pin`

## Requirements
- R1: With `ind_en` low when the read command is recognised, `irq_pin` equals `irq_in` throughout the read, and no interrupt is latched.
- R2: Before the synchronised read-command toggle is seen, `irq_pin` follows the interrupt function even while select is low.
- R3: The read-command toggle is sampled by SYNC_STAGES flops and then detected on the next edge. After that edge the pin is driven high ("not ready") for exactly ARM_CYCLES clock cycles, and only then does it show the empty comparison.
- R4: In indicator mode, the pin is low whenever the read count differs from `wr_cnt`. A change of `wr_cnt` shows at the pin in the same cycle.
- R5: In indicator mode, the pin is high whenever the read count equals `wr_cnt`.
- R6: When `spi_sel_n` rises, the pin shows `irq_in` OR the latched interrupt in the same cycle, with no clock edge needed.
- R7: An `rx_err` pulse during a read holds the pin high for the rest of that read, even after new bytes arrive.
- R8: The error hold is cleared only by deselect. A following read behaves normally.
- R9: An `irq_in` pulse during a read is latched. After deselect the pin is high for SYNC_STAGES+1 clock edges, then returns low.
- R10: Each edge of `rd_tgl` in indicator mode adds one to the read count. The result is visible SYNC_STAGES+1 edges after the toggle.
- R11: The read count restarts at zero with every read command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sel_n | input | 1 | SPI select, low while a transaction is open |
| cmd_tgl | input | 1 | Toggles once per completed buffer-read command byte (SPI domain) |
| rd_tgl | input | 1 | Toggles once per byte shifted out to the host (SPI domain) |
| ind_en | input | 1 | Control bit enabling the indicator mode |
| wr_cnt | input | PTR_W | Number of bytes written into the buffer for this frame |
| rx_err | input | 1 | Receive error such as a synthesiser unlock |
| irq_in | input | 1 | Combined interrupt request |
| irq_pin | output | 1 | Shared pin: interrupt or buffer-empty indicator |

## Verification
The bench sweeps every write count from zero to four and every read count up to it. A comparator that is off by one, or that has its polarity inverted, would release the host one byte early or stall it. The settling window is checked on both of its bounding cycles, so a timer that is one cycle short or one cycle long is caught. An error arriving while data is pending must keep the pin high as the write count grows; a lock that reset on data arrival would let the host read garbage. Interrupts pulsed during a read must appear on the pin right after deselect and clear on the counted edge, which exposes a design that drops them or never releases them.

// File: rtl/frbuf_pkg.sv
package frbuf_pkg;
    typedef enum logic [1:0] {
        MODE_IRQ = 2'd0,
        MODE_ARM = 2'd1,
        MODE_IND = 2'd2
    } pin_mode_e;
endpackage

// File: rtl/frbuf_sync.sv
module frbuf_sync #(
    parameter int     STAGES  = 2,
    parameter logic   RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= RST_VAL;
                    else        chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= RST_VAL;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/frbuf_arm_timer.sv
module frbuf_arm_timer #(
    parameter int ARM_CYCLES = 75
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic done
);
    localparam int CW = (ARM_CYCLES < 2) ? 1 : $clog2(ARM_CYCLES);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        done  = tmr_q.busy && (tmr_q.cnt == '0);
        if (abort) begin
            tmr_d.busy = 1'b0;
            tmr_d.cnt  = '0;
        end else if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CW'(ARM_CYCLES - 1);
        end else if (done) begin
            tmr_d.busy = 1'b0;
        end else if (tmr_q.busy) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_START_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort && ARM_CYCLES > 1) |=> !done); // R3
endmodule

// File: rtl/frbuf_empty_pin.sv
module frbuf_empty_pin
    import frbuf_pkg::*;
#(
    parameter int PTR_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ARM_CYCLES  = 75
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sel_n,
    input  logic             cmd_tgl,
    input  logic             rd_tgl,
    input  logic             ind_en,
    input  logic [PTR_W-1:0] wr_cnt,
    input  logic             rx_err,
    input  logic             irq_in,
    output logic             irq_pin
);
    typedef struct packed {
        pin_mode_e        mode;
        logic             cmd_prev;
        logic             rd_prev;
        logic [PTR_W-1:0] rd_cnt;
        logic             err;
        logic             pend;
    } st_t;

    st_t st_d, st_q;

    logic sel_hi_s, cmd_s, rd_s;
    logic cmd_edge, rd_edge;
    logic tmr_start, tmr_done;
    logic ind_view, mux_ind;

    frbuf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
        .clk(clk), .rst_n(rst_n), .din(spi_sel_n), .dout(sel_hi_s));
    frbuf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_cmd (
        .clk(clk), .rst_n(rst_n), .din(cmd_tgl), .dout(cmd_s));
    frbuf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_rd (
        .clk(clk), .rst_n(rst_n), .din(rd_tgl), .dout(rd_s));

    frbuf_arm_timer #(.ARM_CYCLES(ARM_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .abort(sel_hi_s),
        .done(tmr_done));

    always_comb begin
        st_d          = st_q;
        cmd_edge      = cmd_s ^ st_q.cmd_prev;
        rd_edge       = rd_s ^ st_q.rd_prev;
        st_d.cmd_prev = cmd_s;
        st_d.rd_prev  = rd_s;
        tmr_start     = 1'b0;

        case (st_q.mode)
            MODE_IRQ: begin
                if (cmd_edge && ind_en && !sel_hi_s) begin
                    st_d.mode   = MODE_ARM;
                    st_d.rd_cnt = '0;
                    tmr_start   = 1'b1;
                end
            end
            MODE_ARM: begin
                if (tmr_done) st_d.mode = MODE_IND;
            end
            MODE_IND: begin
                if (rd_edge) st_d.rd_cnt = st_q.rd_cnt + 1'b1;
            end
            default: st_d.mode = MODE_IRQ;
        endcase

        if (st_q.mode != MODE_IRQ && rx_err) st_d.err = 1'b1;

        if (st_q.mode != MODE_IRQ && irq_in)      st_d.pend = 1'b1;
        else if (st_q.mode == MODE_IRQ && sel_hi_s) st_d.pend = 1'b0;

        if (sel_hi_s) begin
            st_d.mode = MODE_IRQ;
            st_d.err  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.mode     <= MODE_IRQ;
        end else begin
            st_q <= st_d;
        end
    end

    assign ind_view = (st_q.mode == MODE_ARM) || st_q.err || (st_q.rd_cnt == wr_cnt);
    assign mux_ind  = (st_q.mode != MODE_IRQ) && !spi_sel_n;
    assign irq_pin  = mux_ind ? ind_view : (irq_in || st_q.pend);

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !sel_hi_s) |=> st_q.err); // R7
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hi_s |=> !st_q.err); // R8
    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hi_s |=> (st_q.mode == MODE_IRQ)); // R6
    AST_NO_ENTRY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_IRQ && !ind_en) |=> (st_q.mode == MODE_IRQ)); // R1
    AST_ARM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_ARM && tmr_done && !sel_hi_s) |=> (st_q.mode == MODE_IND)); // R3
    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && st_q.mode != MODE_IRQ) |=> st_q.pend); // R9
    AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_IND && !sel_hi_s) |=>
        (st_q.rd_cnt == $past(st_q.rd_cnt) || st_q.rd_cnt == $past(st_q.rd_cnt) + 1'b1)); // R10
    AST_RD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.mode == MODE_ARM) |-> (st_q.rd_cnt == '0)); // R11
endmodule

// File: tb/frbuf_empty_pin_tb.sv
module frbuf_empty_pin_tb;
    localparam int PTR_W = 4;
    localparam int SYNC  = 2;
    localparam int ARM   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sel_n = 1'b1;
    logic cmd_tgl = 1'b0;
    logic rd_tgl = 1'b0;
    logic ind_en = 1'b1;
    logic [PTR_W-1:0] wr_cnt = '0;
    logic rx_err = 1'b0;
    logic irq_in = 1'b0;
    logic irq_pin;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    frbuf_empty_pin #(.PTR_W(PTR_W), .SYNC_STAGES(SYNC), .ARM_CYCLES(ARM)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sel_n(spi_sel_n), .cmd_tgl(cmd_tgl),
        .rd_tgl(rd_tgl), .ind_en(ind_en), .wr_cnt(wr_cnt), .rx_err(rx_err),
        .irq_in(irq_in), .irq_pin(irq_pin));

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic exp, input string req);
        checks++;
        if (irq_pin !== exp) begin
            failures++;
            $display("FAIL %s: irq_pin=%b expected=%b at %0t", req, irq_pin, exp, $time);
        end
    endtask

    // open a read: select low, command toggle, wait until indicator mode is live
    task automatic open_read();
        spi_sel_n = 1'b0;
        step(1);
        cmd_tgl = ~cmd_tgl;
        step(SYNC + 1 + ARM);
    endtask

    task automatic close_read();
        spi_sel_n = 1'b1;
        step(SYNC + 3);
    endtask

    task automatic read_byte();
        rd_tgl = ~rd_tgl;
        step(SYNC + 1);
    endtask

    initial begin
        step(3);
        chk(1'b0, "reset R6");
        rst_n = 1'b1;
        step(2);
        chk(1'b0, "reset idle R6");

        // R2: select low with interrupt, no command yet
        spi_sel_n = 1'b0;
        irq_in = 1'b1;
        step(4);
        chk(1'b1, "R2 irq before command");
        irq_in = 1'b0;
        step(1);
        chk(1'b0, "R2 irq low before command");

        // R3: exact arming window with data already available
        wr_cnt = 4'd2;
        cmd_tgl = ~cmd_tgl;
        step(SYNC);
        chk(1'b0, "R2 pin still irq before detect");
        step(1);
        chk(1'b1, "R3 arming starts high");
        step(ARM - 1);
        chk(1'b1, "R3 last arming cycle high");
        step(1);
        chk(1'b0, "R3 R4 indicator live after window");
        close_read();

        // R4 R5 R10 R11: sweep write counts and read counts
        for (int w = 0; w <= 4; w++) begin
            wr_cnt = 4'(w);
            open_read();
            for (int r = 0; r <= w; r++) begin
                chk((r == w) ? 1'b1 : 1'b0, (r == w) ? "R5 R10 R11 empty" : "R4 R10 R11 data");
                if (r < w) read_byte();
            end
            close_read();
        end

        // R4: write count grows while empty, seen at once
        wr_cnt = 4'd1;
        open_read();
        read_byte();
        chk(1'b1, "R5 drained");
        wr_cnt = 4'd2;
        #1;
        chk(1'b0, "R4 new byte same cycle");

        // R7: error locks high despite data
        rx_err = 1'b1;
        step(1);
        rx_err = 1'b0;
        chk(1'b1, "R7 error lock");
        wr_cnt = 4'd5;
        step(3);
        chk(1'b1, "R7 lock survives new data");
        close_read();

        // R8: next read normal
        wr_cnt = 4'd3;
        open_read();
        chk(1'b0, "R8 lock cleared by deselect");

        // R9 R6: interrupt pulse latched and shown on deselect
        irq_in = 1'b1;
        step(1);
        irq_in = 1'b0;
        step(1);
        chk(1'b0, "R9 pulse not shown in indicator mode");
        spi_sel_n = 1'b1;
        #1;
        chk(1'b1, "R6 R9 pending shown at deselect");
        step(SYNC + 1);
        chk(1'b1, "R9 pending still shown");
        step(1);
        chk(1'b0, "R9 pending released");
        step(2);

        // R6: live interrupt shown right at deselect
        open_read();
        irq_in = 1'b1;
        #1;
        chk(1'b0, "R6 live irq masked in indicator mode");
        spi_sel_n = 1'b1;
        #1;
        chk(1'b1, "R6 live irq at deselect");
        irq_in = 1'b0;
        step(SYNC + 3);

        // R1: enable off, pin follows interrupt through a read
        ind_en = 1'b0;
        wr_cnt = 4'd0;
        open_read();
        chk(1'b0, "R1 empty not shown when disabled");
        irq_in = 1'b1;
        step(1);
        chk(1'b1, "R1 irq passes when disabled");
        irq_in = 1'b0;
        step(1);
        chk(1'b0, "R1 irq drop passes when disabled");
        spi_sel_n = 1'b1;
        step(SYNC + 2);
        chk(1'b0, "R1 nothing latched when disabled");
        ind_en = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run hung actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule